// File: doc/BRIEF.md
# Load/Store Address Generator

This unit computes the word address for every data memory access of a small 32-bit load/store processor. The decode stage gives it the primary opcode and the extended opcode, a field that is already sign-extended (either a 22-bit absolute address or a 17-bit displacement), and the values read for the three register fields together with their indices. One clock edge after a request is sampled, the unit presents:

- the memory address;
- one read strobe or one write strobe;
- a select that picks which register value the memory should store;
- the destination of any data loaded from memory;
- for stack operations, the new stack-pointer value and its write enable.

Any register may act as the stack pointer. A push increments the stack register first and stores at the new location. A pop loads from the current location and then decrements the stack register. All addresses count 32-bit words, so a stack step is exactly 1. Every sum wraps modulo 2^32 and raises no fault. The register file, the data memory and full instruction decoding are outside this block.

Top module: `mem_agu`

## Requirements
- R1: Absolute mode (opcode 1 is a load, opcode 3 is a store) sets mem_addr to ext_field. It raises mem_rd for the load and mem_wr for the store, with wdata_sel = 0 (the r1 value is stored). A load sets ld_we = 1 with ld_dst = r1_idx.
- R2: Displacement mode (opcode 2 is a load, opcode 4 is a store) sets mem_addr to ext_field + r2 value. Strobes, wdata_sel and the load destination follow R1.
- R3: Index mode has opcode 31 with extended opcode 16 for a load and 17 for a store. It sets mem_addr to the r2 value + the r3 value. Strobes, wdata_sel and the load destination follow R1.
- R4: Push (opcode 31, extended opcode 20) sets mem_addr to the r1 value + 1 and raises mem_wr with wdata_sel = 1 (the r2 value is stored). It raises sp_we with sp_wdata equal to that same incremented value and leaves ld_we low.
- R5: Pop (opcode 31, extended opcode 21) sets mem_addr to the r1 value and raises mem_rd with ld_we = 1 and ld_dst = r2_idx. It raises sp_we with sp_wdata = r1 value - 1.
- R6: All address and stack arithmetic wraps modulo 2^32. For example, 0xFFFFFFFF + 1 gives 0 and 0 - 1 gives 0xFFFFFFFF.
- R7: An operand whose register index is 0 is taken as zero, whatever value is presented on its value port.
- R8: A pop whose r1 and r2 indices are equal raises sp_we and keeps ld_we low, so the decremented stack pointer is the value that is retained.
- R9: With req_valid low, with any other opcode, or with opcode 31 and any other extended opcode, the next cycle has mem_rd, mem_wr, sp_we and ld_we all low, and mem_addr keeps its previous value.
- R10: While rst_n is low, mem_addr, sp_wdata and ld_dst are 0, and mem_rd, mem_wr, wdata_sel, ld_we and sp_we are 0.
- R11: The outputs change only at the first rising clock edge after the request is sampled. Until that edge they show the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A request is present this cycle |
| opcode | input | 5 | Primary opcode |
| xop | input | 12 | Extended opcode, used when opcode is 31 |
| ext_field | input | 32 | Sign-extended absolute address or displacement |
| r1_idx | input | 5 | Register index in the r1 field |
| r2_idx | input | 5 | Register index in the r2 field |
| r3_idx | input | 5 | Register index in the r3 field |
| r1_val | input | 32 | Value read for the r1 field |
| r2_val | input | 32 | Value read for the r2 field |
| r3_val | input | 32 | Value read for the r3 field |
| mem_addr | output | 32 | Word address of the access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| wdata_sel | output | 1 | Store data select: 0 selects the r1 value, 1 selects the r2 value |
| ld_we | output | 1 | Write loaded data into the register file |
| ld_dst | output | 5 | Register that receives the loaded data |
| sp_we | output | 1 | Write the stack register |
| sp_wdata | output | 32 | New stack-pointer value |

## Verification
A pop asks the register file for two writes in the same cycle: the loaded word goes to the r2 register and the decremented pointer goes to the r1 register. The bench provokes the collision by issuing a pop whose r1 and r2 indices are equal. It then judges the result at the ports, expecting sp_we high with the decremented value and ld_we low. Pops with distinct indices serve as a contrast and must keep both enables high.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int OP_W  = 5;
  localparam int XOP_W = 12;

  localparam logic [OP_W-1:0]  OP_LD_ABS  = 5'd1;
  localparam logic [OP_W-1:0]  OP_LD_DISP = 5'd2;
  localparam logic [OP_W-1:0]  OP_ST_ABS  = 5'd3;
  localparam logic [OP_W-1:0]  OP_ST_DISP = 5'd4;
  localparam logic [OP_W-1:0]  OP_EXT     = 5'd31;

  localparam logic [XOP_W-1:0] XOP_LD_IDX = 12'd16;
  localparam logic [XOP_W-1:0] XOP_ST_IDX = 12'd17;
  localparam logic [XOP_W-1:0] XOP_PUSH   = 12'd20;
  localparam logic [XOP_W-1:0] XOP_POP    = 12'd21;

  typedef enum logic [2:0] {
    AM_NONE,
    AM_ABS,
    AM_DISP,
    AM_IDX,
    AM_PUSH,
    AM_POP
  } addr_mode_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  input  logic [XOP_W-1:0] xop,
  output addr_mode_t       mode,
  output logic             is_write
);
  always_comb begin
    mode     = AM_NONE;
    is_write = 1'b0;
    unique case (opcode)
      OP_LD_ABS:  mode = AM_ABS;
      OP_ST_ABS:  begin mode = AM_ABS;  is_write = 1'b1; end
      OP_LD_DISP: mode = AM_DISP;
      OP_ST_DISP: begin mode = AM_DISP; is_write = 1'b1; end
      OP_EXT: begin
        if (xop == XOP_LD_IDX)      mode = AM_IDX;
        else if (xop == XOP_ST_IDX) begin mode = AM_IDX;  is_write = 1'b1; end
        else if (xop == XOP_PUSH)   begin mode = AM_PUSH; is_write = 1'b1; end
        else if (xop == XOP_POP)    mode = AM_POP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_addr.sv
module agu_addr
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  addr_mode_t    mode,
  input  logic [AW-1:0] ext_field,
  input  logic [AW-1:0] a_val,
  input  logic [AW-1:0] b_val,
  input  logic [AW-1:0] c_val,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] sp_next
);
  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] sp_inc;
  logic [AW-1:0] sp_dec;

  assign sp_inc = a_val + STEP;
  assign sp_dec = a_val - STEP;

  always_comb begin
    unique case (mode)
      AM_ABS:  addr = ext_field;
      AM_DISP: addr = ext_field + b_val;
      AM_IDX:  addr = b_val + c_val;
      AM_PUSH: addr = sp_inc;
      AM_POP:  addr = a_val;
      default: addr = '0;
    endcase
    sp_next = (mode == AM_PUSH) ? sp_inc : sp_dec;
  end
endmodule

// File: rtl/mem_agu.sv
module mem_agu
  import agu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OP_W-1:0]  opcode,
  input  logic [XOP_W-1:0] xop,
  input  logic [AW-1:0]    ext_field,
  input  logic [IDXW-1:0]  r1_idx,
  input  logic [IDXW-1:0]  r2_idx,
  input  logic [IDXW-1:0]  r3_idx,
  input  logic [AW-1:0]    r1_val,
  input  logic [AW-1:0]    r2_val,
  input  logic [AW-1:0]    r3_val,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wdata_sel,
  output logic             ld_we,
  output logic [IDXW-1:0]  ld_dst,
  output logic             sp_we,
  output logic [AW-1:0]    sp_wdata
);
  localparam int NOPS = 3;

  addr_mode_t    mode;
  logic          is_write;
  logic [AW-1:0] raw_val [NOPS];
  logic [AW-1:0] opnd    [NOPS];
  logic [IDXW-1:0] opnd_idx [NOPS];
  logic [AW-1:0] addr_nxt;
  logic [AW-1:0] sp_nxt;

  logic          mem_op;
  logic          rd_nxt, wr_nxt, wsel_nxt, ldwe_nxt, spwe_nxt;
  logic [IDXW-1:0] dst_nxt;

  assign raw_val[0]  = r1_val;
  assign raw_val[1]  = r2_val;
  assign raw_val[2]  = r3_val;
  assign opnd_idx[0] = r1_idx;
  assign opnd_idx[1] = r2_idx;
  assign opnd_idx[2] = r3_idx;

  // register 0 reads as zero (R7)
  for (genvar g = 0; g < NOPS; g++) begin : g_zero
    assign opnd[g] = (opnd_idx[g] == '0) ? '0 : raw_val[g];
  end

  agu_decode u_dec (
    .opcode   (opcode),
    .xop      (xop),
    .mode     (mode),
    .is_write (is_write)
  );

  agu_addr #(.AW(AW)) u_addr (
    .mode      (mode),
    .ext_field (ext_field),
    .a_val     (opnd[0]),
    .b_val     (opnd[1]),
    .c_val     (opnd[2]),
    .addr      (addr_nxt),
    .sp_next   (sp_nxt)
  );

  always_comb begin
    mem_op   = req_valid && (mode != AM_NONE);
    rd_nxt   = mem_op && !is_write;
    wr_nxt   = mem_op && is_write;
    spwe_nxt = mem_op && ((mode == AM_PUSH) || (mode == AM_POP));
    wsel_nxt = (mode == AM_PUSH);
    dst_nxt  = (mode == AM_POP) ? r2_idx : r1_idx;
    // on a pop aliasing the stack register, the pointer update wins (R8)
    ldwe_nxt = rd_nxt && ((mode != AM_POP) || (r1_idx != r2_idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      ld_we  <= 1'b0;
      sp_we  <= 1'b0;
    end else begin
      mem_rd <= rd_nxt;
      mem_wr <= wr_nxt;
      ld_we  <= ldwe_nxt;
      sp_we  <= spwe_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      sp_wdata  <= '0;
      ld_dst    <= '0;
      wdata_sel <= 1'b0;
    end else if (mem_op) begin
      mem_addr  <= addr_nxt;
      sp_wdata  <= sp_nxt;
      ld_dst    <= dst_nxt;
      wdata_sel <= wsel_nxt;
    end
  end

  a_r4_push_sp_equals_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && mem_wr) |-> (sp_wdata == mem_addr && wdata_sel));

  a_r5_pop_sp_below_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && mem_rd) |-> (sp_wdata == mem_addr - AW'(1)));

  a_r8_pop_alias_sp_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == OP_EXT && xop == XOP_POP && r1_idx == r2_idx)
      |=> (sp_we && !ld_we && mem_rd));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_rd && !mem_wr && !sp_we && !ld_we));

  a_r9_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(mem_addr));

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> (mem_rd && !mem_wr));
endmodule

// File: tb/mem_agu_bench.sv
module mem_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  opcode = '0;
  logic [11:0] xop = '0;
  logic [31:0] ext_field = '0;
  logic [4:0]  r1_idx = '0, r2_idx = '0, r3_idx = '0;
  logic [31:0] r1_val = '0, r2_val = '0, r3_val = '0;
  logic [31:0] mem_addr, sp_wdata;
  logic        mem_rd, mem_wr, wdata_sel, ld_we, sp_we;
  logic [4:0]  ld_dst;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mem_agu u_mem_agu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode), .xop(xop),
    .ext_field(ext_field), .r1_idx(r1_idx), .r2_idx(r2_idx), .r3_idx(r3_idx),
    .r1_val(r1_val), .r2_val(r2_val), .r3_val(r3_val), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wdata_sel(wdata_sel), .ld_we(ld_we),
    .ld_dst(ld_dst), .sp_we(sp_we), .sp_wdata(sp_wdata)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // all strobe-type outputs packed: {rd, wr, wsel, ld_we, sp_we}
  function automatic logic [31:0] flags();
    return {27'd0, mem_rd, mem_wr, wdata_sel, ld_we, sp_we};
  endfunction

  // drive one request at a negedge, sample one cycle later at the next negedge
  task automatic issue(logic v, logic [4:0] op, logic [11:0] x, logic [31:0] e,
                       logic [4:0] i1, logic [4:0] i2, logic [4:0] i3,
                       logic [31:0] v1, logic [31:0] v2, logic [31:0] v3);
    req_valid = v; opcode = op; xop = x; ext_field = e;
    r1_idx = i1; r2_idx = i2; r3_idx = i3;
    r1_val = v1; r2_val = v2; r3_val = v3;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10", "addr", mem_addr, 32'd0);
    chk("R10", "flags", flags(), 32'd0);
    chk("R10", "sp_wdata", sp_wdata, 32'd0);
  endtask

  task automatic t_absolute();
    issue(1, 5'd1, 0, 32'hFFFF_FFFB, 5'd7, 0, 0, 0, 0, 0);
    chk("R1", "ld addr", mem_addr, 32'hFFFF_FFFB);
    chk("R1", "ld flags", flags(), 32'b10010);
    chk("R1", "ld dst", {27'd0, ld_dst}, 32'd7);
    issue(1, 5'd3, 0, 32'd1234, 5'd4, 0, 0, 32'd9, 0, 0);
    chk("R1", "st addr", mem_addr, 32'd1234);
    chk("R1", "st flags", flags(), 32'b01000);
  endtask

  task automatic t_disp();
    issue(1, 5'd2, 0, 32'hFFFF_FFFD, 5'd3, 5'd5, 0, 0, 32'd10, 0);
    chk("R2", "ld addr", mem_addr, 32'd7);
    chk("R2", "ld flags", flags(), 32'b10010);
    issue(1, 5'd4, 0, 32'd100, 5'd3, 5'd5, 0, 0, 32'd50, 0);
    chk("R2", "st addr", mem_addr, 32'd150);
    chk("R2", "st flags", flags(), 32'b01000);
  endtask

  task automatic t_index();
    issue(1, 5'd31, 12'd16, 32'd999, 5'd2, 5'd8, 5'd9, 0, 32'd300, 32'd45);
    chk("R3", "ld addr", mem_addr, 32'd345);
    chk("R3", "ld flags", flags(), 32'b10010);
    chk("R3", "ld dst", {27'd0, ld_dst}, 32'd2);
    issue(1, 5'd31, 12'd17, 32'd999, 5'd2, 5'd8, 5'd9, 0, 32'd7, 32'd8);
    chk("R3", "st addr", mem_addr, 32'd15);
    chk("R3", "st flags", flags(), 32'b01000);
  endtask

  task automatic t_stack();
    issue(1, 5'd31, 12'd20, 0, 5'd29, 5'd6, 0, 32'd100, 32'd77, 0);
    chk("R4", "push addr", mem_addr, 32'd101);
    chk("R4", "push flags", flags(), 32'b01101);
    chk("R4", "push sp", sp_wdata, 32'd101);
    issue(1, 5'd31, 12'd21, 0, 5'd29, 5'd6, 0, 32'd50, 32'd77, 0);
    chk("R5", "pop addr", mem_addr, 32'd50);
    chk("R5", "pop flags", flags(), 32'b10011);
    chk("R5", "pop sp", sp_wdata, 32'd49);
    chk("R5", "pop dst", {27'd0, ld_dst}, 32'd6);
  endtask

  task automatic t_wrap();
    issue(1, 5'd2, 0, 32'd1, 5'd1, 5'd2, 0, 0, 32'hFFFF_FFFF, 0);
    chk("R6", "disp wrap", mem_addr, 32'd0);
    issue(1, 5'd31, 12'd20, 0, 5'd3, 5'd4, 0, 32'hFFFF_FFFF, 0, 0);
    chk("R6", "push wrap addr", mem_addr, 32'd0);
    chk("R6", "push wrap sp", sp_wdata, 32'd0);
    issue(1, 5'd31, 12'd21, 0, 5'd3, 5'd4, 0, 32'd0, 0, 0);
    chk("R6", "pop wrap sp", sp_wdata, 32'hFFFF_FFFF);
  endtask

  task automatic t_zero_reg();
    issue(1, 5'd2, 0, 32'd20, 5'd1, 5'd0, 0, 0, 32'd999, 0);
    chk("R7", "disp r0", mem_addr, 32'd20);
    issue(1, 5'd31, 12'd16, 0, 5'd1, 5'd4, 5'd0, 0, 32'd60, 32'd555);
    chk("R7", "index r0", mem_addr, 32'd60);
  endtask

  task automatic t_alias();
    issue(1, 5'd31, 12'd21, 0, 5'd12, 5'd12, 0, 32'd80, 32'd80, 0);
    chk("R8", "alias flags", flags(), 32'b10001);
    chk("R8", "alias sp", sp_wdata, 32'd79);
  endtask

  task automatic t_idle();
    issue(1, 5'd3, 0, 32'd4242, 5'd1, 0, 0, 0, 0, 0);
    issue(1, 5'd10, 0, 32'd77, 5'd1, 5'd2, 0, 32'd5, 32'd6, 0);
    chk("R9", "alu op flags", flags(), 32'd0);
    chk("R9", "alu op addr", mem_addr, 32'd4242);
    issue(1, 5'd31, 12'd22, 32'd88, 5'd1, 5'd2, 0, 32'd5, 32'd6, 0);
    chk("R9", "bad xop flags", flags(), 32'd0);
    issue(0, 5'd1, 0, 32'd66, 5'd1, 0, 0, 0, 0, 0);
    chk("R9", "no valid flags", flags(), 32'd0);
    chk("R9", "no valid addr", mem_addr, 32'd4242);
  endtask

  task automatic t_latency();
    req_valid = 1; opcode = 5'd1; ext_field = 32'd5555; r1_idx = 5'd1;
    #5;
    chk("R11", "before edge", mem_addr, 32'd4242);
    @(negedge clk);
    req_valid = 0;
    chk("R11", "after edge", mem_addr, 32'd5555);
  endtask

  initial begin
    #15;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_absolute();
    t_disp();
    t_index();
    t_stack();
    t_wrap();
    t_zero_reg();
    t_alias();
    t_idle();
    t_latency();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule